// File: doc/BRIEF.md
# Direct-Mapped Read-Only Line Cache

This block sits between a processor fetch port and a slower backing memory and answers word reads from a local store of 512 lines of 32 bytes each, 16 KB in all. Each read address is split into a tag, a line index and a word select. The indexed line's stored tag and valid flag decide whether the read hits. A hit is answered from the local store in the following cycle, with no memory traffic.

On a miss the block stops taking requests and asks memory for the whole line. It then takes the eight words of the line in ascending order and writes each one into the line store. The requested word goes back to the processor as soon as its beat arrives, so the response does not wait for the rest of the line. When the last beat lands, the tag is recorded and the line is marked valid. A single-cycle invalidate pulse drops every line at once. This is used after the backing memory contents change.

Top module: `ro_line_cache`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0 and mem_req_valid is 0, and every line is invalid.
- R2: A request address is decoded as word select = bits 4:2, line index = bits 13:5 and tag = bits 31:14; bits 1:0 are ignored.
- R3: A request accepted (req_valid and req_ready high at a rising edge) hits when the indexed line is valid and its stored tag equals the request tag; a hit drives rsp_valid for one cycle right after the acceptance edge, with the stored word in rsp_data, and issues no memory request.
- R4: A miss raises mem_req_valid in the cycle after acceptance with mem_req_addr = {tag, index, 5'b0}, and holds both unchanged until mem_req_ready is seen high at a rising edge.
- R5: After the memory handshake, the refill takes eight beats on mem_rsp_valid, holding words 0 to 7 of the line in order. Every beat is written into the line. On the last beat the tag is stored and the line becomes valid, so later reads of any word in it hit with the refilled data.
- R6: During a refill, the requested word is driven on rsp_data with rsp_valid for one cycle, in the cycle after its own beat is taken, even when later beats of the line are still outstanding.
- R7: req_ready is 0 from the cycle after a miss is accepted until the cycle after the final refill beat, and no request is taken meanwhile.
- R8: A one-cycle inval_all pulse, given while no refill is in progress, clears every valid flag at the next edge, so the next read of any line misses even if its stored tag matches.
- R9: Two addresses 16 KB apart share a line; filling one evicts the other, so alternating reads between them miss every time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Processor read request present |
| req_addr | input | 32 | Processor byte address of the word to read |
| req_ready | output | 1 | Cache can take a request this cycle |
| rsp_valid | output | 1 | Read data valid, one cycle per request |
| rsp_data | output | 32 | Read data word |
| mem_req_valid | output | 1 | Line fetch request to backing memory |
| mem_req_addr | output | 32 | Line-aligned fetch address |
| mem_req_ready | input | 1 | Backing memory takes the fetch request |
| mem_rsp_valid | input | 1 | Refill beat present |
| mem_rsp_data | input | 32 | Refill beat data, word 0 first |
| inval_all | input | 1 | Invalidate every line |

## Verification
The bench keeps its own tag and valid model and a memory content function. It goes after hits that depend on the valid flag rather than only the tag. A design that ignores the flag would return stale data after an invalidate, or return garbage from a line that was never filled. Aliased addresses one capacity apart are alternated to catch a wrong index or tag split, which would show up as false hits or as requests for the wrong line. Misses on word 0 and word 7 are aimed at the forwarding point, and the memory withholds ready and inserts gaps between beats. An off-by-one beat count would forward a neighbouring word. A controller that waited for the whole line would answer only after req_ready came back.

// File: rtl/ro_cache_pkg.sv
// Package: shared types for the read-only line cache.
// Assumes: nothing beyond the standard language.
package ro_cache_pkg;

    // Refill controller phases
    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,   // taking lookups
        FS_ASK  = 2'd1,   // line request waiting on memory
        FS_FILL = 2'd2    // collecting refill beats
    } fill_state_t;

endpackage

// File: rtl/lc_tag_store.sv
// Module: lc_tag_store
// Holds one tag and one valid flag per line. Reads are combinational.
// Assumes: a write and an invalidate in the same cycle resolve to invalid.
module lc_tag_store #(
    parameter int NUM_LINES = 512,
    parameter int IDX_W     = 9,
    parameter int TAG_W     = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [TAG_W-1:0] rd_tag,
    output logic             rd_valid,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic             inval_all
);

    logic [TAG_W-1:0]     tags_q [NUM_LINES];
    logic [NUM_LINES-1:0] valid_q;

    // Valid flags: cleared by reset or invalidate, set on line completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (inval_all) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
        end
    end

    // Tag array: written once per completed refill, no reset needed
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tags_q[wr_idx] <= wr_tag;
        end
    end

    assign rd_tag   = tags_q[rd_idx];
    assign rd_valid = valid_q[rd_idx];

endmodule

// File: rtl/lc_data_store.sv
// Module: lc_data_store
// Line data array, one packed line per entry, one word written per cycle.
// Assumes: reads are combinational and only trusted when the tag store says valid.
module lc_data_store #(
    parameter int NUM_LINES  = 512,
    parameter int LINE_WORDS = 8,
    parameter int DATA_W     = 32,
    parameter int IDX_W      = 9,
    parameter int WSEL_W     = 3
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WSEL_W-1:0] wr_word,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [WSEL_W-1:0] rd_word,
    output logic [DATA_W-1:0] rd_data
);

    logic [LINE_WORDS-1:0][DATA_W-1:0] lines_q [NUM_LINES];

    // Word write from the refill stream
    always_ff @(posedge clk) begin
        if (wr_en) begin
            lines_q[wr_idx][wr_word] <= wr_data;
        end
    end

    assign rd_data = lines_q[rd_idx][rd_word];

endmodule

// File: rtl/lc_refill_ctrl.sv
// Module: lc_refill_ctrl
// Accepts lookups, answers hits, runs the line refill on a miss and
// forwards the requested word when its beat arrives.
// Assumes: memory returns exactly LINE_WORDS beats, word 0 first, after
// the request handshake; responses have no backpressure.
module lc_refill_ctrl
    import ro_cache_pkg::*;
#(
    parameter int LINE_WORDS = 8,
    parameter int DATA_W     = 32,
    parameter int IDX_W      = 9,
    parameter int TAG_W      = 18,
    parameter int WSEL_W     = 3,
    parameter int OFF_W      = 5
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           req_valid,
    input  logic [IDX_W-1:0]               req_idx,
    input  logic [TAG_W-1:0]               req_tag,
    input  logic [WSEL_W-1:0]              req_word,
    input  logic                           lookup_hit,
    input  logic [DATA_W-1:0]              hit_data,
    output logic                           req_ready,
    output logic                           rsp_valid,
    output logic [DATA_W-1:0]              rsp_data,
    output logic                           mem_req_valid,
    output logic [TAG_W+IDX_W+OFF_W-1:0]   mem_req_addr,
    input  logic                           mem_req_ready,
    input  logic                           mem_rsp_valid,
    input  logic [DATA_W-1:0]              mem_rsp_data,
    output logic                           fill_we,
    output logic [IDX_W-1:0]               fill_idx,
    output logic [WSEL_W-1:0]              fill_word,
    output logic                           tag_we,
    output logic [TAG_W-1:0]               tag_val
);

    fill_state_t        state_q;
    logic [IDX_W-1:0]   idx_q;
    logic [TAG_W-1:0]   tag_q;
    logic [WSEL_W-1:0]  word_q;
    logic [WSEL_W-1:0]  beat_q;
    logic               rsp_v_q;
    logic [DATA_W-1:0]  rsp_d_q;
    logic               last_beat;

    assign last_beat = (beat_q == WSEL_W'(LINE_WORDS - 1));

    // Phase sequencing, miss capture, beat count and response register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FS_IDLE;
            idx_q   <= '0;
            tag_q   <= '0;
            word_q  <= '0;
            beat_q  <= '0;
            rsp_v_q <= 1'b0;
            rsp_d_q <= '0;
        end else begin
            rsp_v_q <= 1'b0;
            case (state_q)
                FS_IDLE: begin
                    if (req_valid) begin
                        if (lookup_hit) begin
                            rsp_v_q <= 1'b1;
                            rsp_d_q <= hit_data;
                        end else begin
                            idx_q   <= req_idx;
                            tag_q   <= req_tag;
                            word_q  <= req_word;
                            state_q <= FS_ASK;
                        end
                    end
                end
                FS_ASK: begin
                    if (mem_req_ready) begin
                        beat_q  <= '0;
                        state_q <= FS_FILL;
                    end
                end
                FS_FILL: begin
                    if (mem_rsp_valid) begin
                        beat_q <= beat_q + 1'b1;
                        if (beat_q == word_q) begin
                            rsp_v_q <= 1'b1;
                            rsp_d_q <= mem_rsp_data;
                        end
                        if (last_beat) begin
                            state_q <= FS_IDLE;
                        end
                    end
                end
                default: state_q <= FS_IDLE;
            endcase
        end
    end

    assign req_ready     = (state_q == FS_IDLE);
    assign rsp_valid     = rsp_v_q;
    assign rsp_data      = rsp_d_q;
    assign mem_req_valid = (state_q == FS_ASK);
    assign mem_req_addr  = {tag_q, idx_q, {OFF_W{1'b0}}};
    assign fill_we       = (state_q == FS_FILL) && mem_rsp_valid;
    assign fill_idx      = idx_q;
    assign fill_word     = beat_q;
    assign tag_we        = fill_we && last_beat;
    assign tag_val       = tag_q;

endmodule

// File: rtl/ro_line_cache.sv
// Module: ro_line_cache (top)
// Direct-mapped read-only cache: splits the request address, looks up
// tag and valid flag, and hands hits and misses to the refill controller.
// Assumes: inval_all is pulsed only while no refill is in progress.
module ro_line_cache #(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int NUM_LINES  = 512,
    parameter int LINE_WORDS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_req_ready,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data,
    input  logic              inval_all
);

    localparam int BYTE_W = $clog2(DATA_W / 8);
    localparam int WSEL_W = $clog2(LINE_WORDS);
    localparam int OFF_W  = WSEL_W + BYTE_W;
    localparam int IDX_W  = $clog2(NUM_LINES);
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;

    logic [WSEL_W-1:0] req_word;
    logic [IDX_W-1:0]  req_idx;
    logic [TAG_W-1:0]  req_tag;
    logic [TAG_W-1:0]  stored_tag;
    logic              stored_valid;
    logic              lookup_hit;
    logic [DATA_W-1:0] hit_data;
    logic              fill_we;
    logic [IDX_W-1:0]  fill_idx;
    logic [WSEL_W-1:0] fill_word;
    logic              tag_we;
    logic [TAG_W-1:0]  tag_val;
    logic              byte_sel_unused;

    assign req_word        = req_addr[OFF_W-1:BYTE_W];
    assign req_idx         = req_addr[OFF_W+IDX_W-1:OFF_W];
    assign req_tag         = req_addr[ADDR_W-1:OFF_W+IDX_W];
    assign byte_sel_unused = ^req_addr[BYTE_W-1:0];
    assign lookup_hit      = stored_valid && (stored_tag == req_tag);

    lc_tag_store #(
        .NUM_LINES (NUM_LINES),
        .IDX_W     (IDX_W),
        .TAG_W     (TAG_W)
    ) u_tags (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx    (req_idx),
        .rd_tag    (stored_tag),
        .rd_valid  (stored_valid),
        .wr_en     (tag_we),
        .wr_idx    (fill_idx),
        .wr_tag    (tag_val),
        .inval_all (inval_all)
    );

    lc_data_store #(
        .NUM_LINES  (NUM_LINES),
        .LINE_WORDS (LINE_WORDS),
        .DATA_W     (DATA_W),
        .IDX_W      (IDX_W),
        .WSEL_W     (WSEL_W)
    ) u_data (
        .clk     (clk),
        .wr_en   (fill_we),
        .wr_idx  (fill_idx),
        .wr_word (fill_word),
        .wr_data (mem_rsp_data),
        .rd_idx  (req_idx),
        .rd_word (req_word),
        .rd_data (hit_data)
    );

    lc_refill_ctrl #(
        .LINE_WORDS (LINE_WORDS),
        .DATA_W     (DATA_W),
        .IDX_W      (IDX_W),
        .TAG_W      (TAG_W),
        .WSEL_W     (WSEL_W),
        .OFF_W      (OFF_W)
    ) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_idx       (req_idx),
        .req_tag       (req_tag),
        .req_word      (req_word),
        .lookup_hit    (lookup_hit),
        .hit_data      (hit_data),
        .req_ready     (req_ready),
        .rsp_valid     (rsp_valid),
        .rsp_data      (rsp_data),
        .mem_req_valid (mem_req_valid),
        .mem_req_addr  (mem_req_addr),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .fill_we       (fill_we),
        .fill_idx      (fill_idx),
        .fill_word     (fill_word),
        .tag_we        (tag_we),
        .tag_val       (tag_val)
    );

endmodule

// File: rtl/ro_line_cache_checks.sv
// Module: ro_line_cache_checks
// Port-level protocol properties of the cache, bound to the top module.
// Assumes: synchronous active-low reset on rst_n.
module ro_line_cache_checks #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [ADDR_W-1:0] mem_req_addr
);

    // An accepted request is answered at once on a hit or turns into a line fetch
    assert_turnaround_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (rsp_valid || mem_req_valid));

    // A pending line fetch keeps its request and address until taken
    assert_fetch_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // A line fetch only starts right after a request was accepted
    assert_fetch_origin_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req_valid) |-> $past(req_valid && req_ready));

    // No new requests are taken while a fetch is outstanding
    assert_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !req_ready);

    // No response while still waiting for memory to take the fetch
    assert_quiet_ask_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !rsp_valid);

endmodule

bind ro_line_cache ro_line_cache_checks #(.ADDR_W(ADDR_W)) u_checks (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .rsp_valid     (rsp_valid),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr)
);

// File: tb/ro_line_cache_test.sv
`timescale 1ns/1ps
module ro_line_cache_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_ready;
    logic        rsp_valid;
    logic [31:0] rsp_data;
    logic        mem_req_valid;
    logic [31:0] mem_req_addr;
    logic        mem_req_ready = 1'b0;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        inval_all = 1'b0;

    int vectors = 0;
    int errors  = 0;

    logic [17:0] model_tag   [512];
    logic        model_valid [512];

    logic        hs_seen = 1'b0;
    logic [31:0] hs_addr = '0;

    always #2 clk = ~clk;

    ro_line_cache uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_addr      (req_addr),
        .req_ready     (req_ready),
        .rsp_valid     (rsp_valid),
        .rsp_data      (rsp_data),
        .mem_req_valid (mem_req_valid),
        .mem_req_addr  (mem_req_addr),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .inval_all     (inval_all)
    );

    // Backing memory content, a fixed function of the word address
    function automatic logic [31:0] mem_word(input logic [31:0] a);
        logic [31:0] w;
        w = {a[31:2], 2'b00};
        return (w * 32'h9E37_79B1) ^ 32'h0BAD_F00D;
    endfunction

    function automatic logic [31:0] make_addr(input int tag, input int idx, input int word);
        return {18'(tag), 9'(idx), 3'(word), 2'b00};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Record memory request handshakes at the edge
    always @(posedge clk) begin
        hs_seen <= mem_req_valid && mem_req_ready;
        hs_addr <= mem_req_addr;
    end

    // Memory responder: random request ready, eight beats with random gaps
    initial begin
        int          left = 0;
        int          beat = 0;
        logic [31:0] base = '0;
        forever begin
            @(negedge clk);
            if (hs_seen) begin
                left = 8;
                beat = 0;
                base = hs_addr;
            end
            mem_rsp_valid = 1'b0;
            mem_req_ready = 1'b0;
            if (left > 0) begin
                if (($urandom % 4) != 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = mem_word(base + 32'(beat * 4));
                    beat++;
                    left--;
                end
            end else begin
                mem_req_ready = (($urandom % 3) != 0);
            end
        end
    end

    task automatic do_read(input logic [31:0] addr, input string ctx);
        int          idx = int'(addr[13:5]);
        int          word = int'(addr[4:2]);
        logic [17:0] tag = addr[31:14];
        bit          exp_hit = model_valid[idx] && (model_tag[idx] == tag);
        bit          got = 0;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_addr  = addr;
        @(negedge clk);
        req_valid = 1'b0;
        // R3 hit classification: response one cycle after acceptance only on a hit
        check(rsp_valid == exp_hit, {"R3 hit/miss ", ctx}, 32'(rsp_valid), 32'(exp_hit));
        if (rsp_valid) begin
            check(rsp_data == mem_word(addr), {"R5 hit data ", ctx}, rsp_data, mem_word(addr));
        end else begin
            // R4 line request address; R7 stall
            check(mem_req_valid && mem_req_addr == {addr[31:5], 5'b0}, {"R4 line request ", ctx},
                  mem_req_addr, {addr[31:5], 5'b0});
            check(!req_ready, {"R7 stalled ", ctx}, 32'(req_ready), 32'd0);
            for (int n = 0; n < 400; n++) begin
                @(negedge clk);
                if (rsp_valid) begin
                    got = 1;
                    break;
                end
            end
            check(got && rsp_data == mem_word(addr), {"R6 forwarded data ", ctx}, rsp_data, mem_word(addr));
            // R6: words before the last come back while the fill is still open
            if (word < 7)
                check(!req_ready, {"R6 early forward ", ctx}, 32'(req_ready), 32'd0);
            else
                check(req_ready, {"R7 ready after last beat ", ctx}, 32'(req_ready), 32'd1);
            model_tag[idx]   = tag;
            model_valid[idx] = 1'b1;
        end
    endtask

    task automatic pulse_inval();
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        inval_all = 1'b1;
        @(negedge clk);
        inval_all = 1'b0;
        for (int i = 0; i < 512; i++) model_valid[i] = 1'b0;
    endtask

    // Watchdog: a hung run is a failure and still reports
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %h expected %h", 32'd1, 32'd0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 512; i++) begin
            model_valid[i] = 1'b0;
            model_tag[i]   = '0;
        end
        repeat (4) @(negedge clk);
        // R1 reset state
        check(req_ready && !rsp_valid && !mem_req_valid, "R1 reset outputs",
              {29'd0, req_ready, rsp_valid, mem_req_valid}, 32'h4);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready && !rsp_valid && !mem_req_valid, "R1 after reset release",
              {29'd0, req_ready, rsp_valid, mem_req_valid}, 32'h4);

        // Directed: cold miss on word 0, then hits on other words of the line (R2, R5)
        do_read(make_addr(5, 17, 0), "cold word0");
        do_read(make_addr(5, 17, 7), "R5 refilled word7");
        do_read(make_addr(5, 17, 3) | 32'h3, "R2 byte bits ignored");
        // Directed: miss on word 7, forwarded with the last beat
        do_read(make_addr(2, 300, 7), "cold word7");
        do_read(make_addr(2, 300, 0), "R5 refilled word0");
        // Directed: aliasing 16 KB apart (R9)
        do_read(make_addr(6, 17, 1), "R9 alias evicts");
        do_read(make_addr(5, 17, 1), "R9 alias back");
        do_read(make_addr(6, 17, 1), "R9 alias again");
        // Directed: invalidate makes a matching tag miss (R8)
        pulse_inval();
        do_read(make_addr(6, 17, 1), "R8 after invalidate");
        do_read(make_addr(2, 300, 4), "R8 other line after invalidate");
        do_read(make_addr(2, 300, 4), "R8 refilled after invalidate");

        // Constrained random mix with occasional invalidates
        for (int k = 0; k < 400; k++) begin
            if (($urandom % 40) == 0) pulse_inval();
            do_read(make_addr(int'($urandom % 3), int'($urandom % 8), int'($urandom % 8)), "random");
        end

        repeat (4) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule